// File: doc/BRIEF.md
# DRAM Direct Command Port

This block is a single 32-bit software-visible register that lets firmware put one DRAM command at a time onto a DRAM command bus. Typical uses are the power-up sequence and calibration steps: precharge-all, refresh, mode-register writes and ZQ calibration. A write that has the start bit set and carries a defined opcode launches the command. In the following cycle the command bus carries the opcode, the chip selects, the bank address and the address for exactly one cycle. After that cycle the bus returns to deselect.

The start bit reads back as 1 while the command is outstanding. It clears once a minimum spacing has elapsed, and that spacing depends on the command. Software therefore polls bit 31 until it reads 0 before it issues the next command. Writes that arrive while a command is outstanding are dropped. Writes that carry an opcode the block does not define complete at once and cause no bus activity.

Top module: `dram_cmd_port`

## Requirements
- R1: After reset, `rd_data` reads 0 and all command bus outputs (`bus_cs`, `bus_ba`, `bus_addr`, `bus_cmd`) are 0, which is deselect.
- R2: The register word is laid out as follows: bit 31 is start, bits 21:20 are the rank mask, bits 19:17 are the bank, bits 16:4 are the address and bits 3:0 are the opcode. Bits 30:22 read as 0. While the block is idle, a write stores the rank, bank, address and opcode fields, and `rd_data` returns them from the next cycle on.
- R3: An idle write with start set and a defined opcode other than 0 puts that opcode on `bus_cmd` in the cycle after the write edge. In the same cycle `bus_cs` carries the rank mask, `bus_ba` the bank and `bus_addr` the address. Every bus output is 0 in the cycle after that.
- R4: The opcode codes are 0 deselect, 1 precharge all, 2 refresh, 3 mode-register set, 4 ZQ short, 5 ZQ long, 6 reset-low and 8 mode-register read. Opcode 0 launches but leaves every bus output at 0.
- R5: After a launch, bit 31 reads 1 for exactly a fixed number of cycles, starting in the cycle after the write edge. That number is T_LONG for refresh and ZQ long, T_MRS for mode-register set and T_BASE for every other defined opcode.
- R6: A write while bit 31 reads 1 is ignored. It changes no stored field, drives no bus activity and does not change the busy length.
- R7: An idle write with start set and an undefined opcode (7, or 9 through 15) drives no bus activity and leaves bit 31 at 0. Its fields are still stored as in R2.
- R8: An idle write with start clear stores the fields but launches nothing: the bus stays at 0 and bit 31 stays 0.
- R9: A rank mask of 3 asserts both bits of `bus_cs` in the command cycle. A mask of 0 asserts neither, while the opcode is still driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write word |
| rd_data | output | 32 | Register read value: busy in bit 31, stored fields below it |
| bus_cs | output | 2 | Chip selects, active high, one per rank |
| bus_ba | output | 3 | Bank address |
| bus_addr | output | 13 | Command address |
| bus_cmd | output | 4 | Command type, 0 means deselect/NOP |

## Verification
A wrong spacing count shows up as a start bit that clears one or more cycles early or late. That appears at `rd_data[31]` within the longest spacing after the launch. A bad opcode classification appears in the first cycle after the write, either as a bus pulse where none belongs or as a missing one. A busy flag that drops or latches the wrong fields becomes visible when the stored fields are read back in the cycle after an ignored write.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_DESEL = 4'd0,
    OP_PREA  = 4'd1,
    OP_REF   = 4'd2,
    OP_MRS   = 4'd3,
    OP_ZQS   = 4'd4,
    OP_ZQL   = 4'd5,
    OP_RSTL  = 4'd6,
    OP_MRR   = 4'd8
  } dcp_op_e;

  // True for every opcode the port knows how to drive.
  function automatic logic op_defined(input logic [OP_W-1:0] op);
    return (op <= 4'd6) || (op == 4'd8);
  endfunction

  // Busy spacing in cycles for a defined opcode.
  function automatic int op_gap(input logic [OP_W-1:0] op,
                                input int t_base, input int t_mrs,
                                input int t_long);
    case (op)
      OP_REF, OP_ZQL: return t_long;
      OP_MRS:         return t_mrs;
      default:        return t_base;
    endcase
  endfunction

endpackage

// File: rtl/dcp_field_decode.sv
module dcp_field_decode
  import dcp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 3,
  parameter int RANK_W = 2
) (
  input  logic [31:0]        word,
  output logic               start,
  output logic [OP_W-1:0]    op,
  output logic [ADDR_W-1:0]  addr,
  output logic [BA_W-1:0]    ba,
  output logic [RANK_W-1:0]  rank,
  output logic               legal
);
  localparam int ADDR_LSB = OP_W;
  localparam int BA_LSB   = ADDR_LSB + ADDR_W;
  localparam int RANK_LSB = BA_LSB + BA_W;
  localparam int TOP_USED = RANK_LSB + RANK_W;

  assign start = word[31];
  assign op    = word[OP_W-1:0];
  assign addr  = word[BA_LSB-1:ADDR_LSB];
  assign ba    = word[RANK_LSB-1:BA_LSB];
  assign rank  = word[TOP_USED-1:RANK_LSB];
  assign legal = op_defined(op);

  logic unused_pad;
  assign unused_pad = ^word[30:TOP_USED];
endmodule

// File: rtl/dcp_gap_timer.sv
module dcp_gap_timer
  import dcp_pkg::*;
#(
  parameter int T_BASE = 2,
  parameter int T_MRS  = 4,
  parameter int T_LONG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [OP_W-1:0] op,
  output logic            busy
);
  localparam int CNT_W = $clog2(T_LONG + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CNT_W'(op_gap(op, T_BASE, T_MRS, T_LONG));
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/dcp_bus_driver.sv
module dcp_bus_driver
  import dcp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 3,
  parameter int RANK_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [OP_W-1:0]    op,
  input  logic [RANK_W-1:0]  rank,
  input  logic [BA_W-1:0]    ba,
  input  logic [ADDR_W-1:0]  addr,
  output logic [RANK_W-1:0]  bus_cs,
  output logic [BA_W-1:0]    bus_ba,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [OP_W-1:0]    bus_cmd
);
  logic drive;
  assign drive = fire && (op != OP_DESEL);

  always_ff @(posedge clk) begin
    if (!rst_n || !drive) begin
      bus_cs   <= '0;
      bus_ba   <= '0;
      bus_addr <= '0;
      bus_cmd  <= '0;
    end else begin
      bus_cs   <= rank;
      bus_ba   <= ba;
      bus_addr <= addr;
      bus_cmd  <= op;
    end
  end
endmodule

// File: rtl/dram_cmd_port.sv
module dram_cmd_port
  import dcp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 3,
  parameter int RANK_W = 2,
  parameter int T_BASE = 2,
  parameter int T_MRS  = 4,
  parameter int T_LONG = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic [RANK_W-1:0]  bus_cs,
  output logic [BA_W-1:0]    bus_ba,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [OP_W-1:0]    bus_cmd
);
  localparam int PAD_W = 31 - (RANK_W + BA_W + ADDR_W + OP_W);

  logic              w_start, w_legal;
  logic [OP_W-1:0]   w_op;
  logic [ADDR_W-1:0] w_addr;
  logic [BA_W-1:0]   w_ba;
  logic [RANK_W-1:0] w_rank;

  // Named events shared with the checker.
  logic busy, accept, launch;

  dcp_field_decode #(.ADDR_W(ADDR_W), .BA_W(BA_W), .RANK_W(RANK_W)) u_dec (
    .word(wr_data), .start(w_start), .op(w_op), .addr(w_addr),
    .ba(w_ba), .rank(w_rank), .legal(w_legal)
  );

  assign accept = wr_en && !busy;
  assign launch = accept && w_start && w_legal;

  dcp_gap_timer #(.T_BASE(T_BASE), .T_MRS(T_MRS), .T_LONG(T_LONG)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(launch), .op(w_op), .busy(busy)
  );

  dcp_bus_driver #(.ADDR_W(ADDR_W), .BA_W(BA_W), .RANK_W(RANK_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .fire(launch), .op(w_op), .rank(w_rank),
    .ba(w_ba), .addr(w_addr), .bus_cs(bus_cs), .bus_ba(bus_ba),
    .bus_addr(bus_addr), .bus_cmd(bus_cmd)
  );

  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BA_W-1:0]   ba_q;
  logic [RANK_W-1:0] rank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0; addr_q <= '0; ba_q <= '0; rank_q <= '0;
    end else if (accept) begin
      op_q <= w_op; addr_q <= w_addr; ba_q <= w_ba; rank_q <= w_rank;
    end
  end

  assign rd_data = {busy, {PAD_W{1'b0}}, rank_q, ba_q, addr_q, op_q};
endmodule

// File: rtl/dram_cmd_port_chk.sv
module dram_cmd_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic [1:0]  bus_cs,
  input logic [2:0]  bus_ba,
  input logic [12:0] bus_addr,
  input logic [3:0]  bus_cmd,
  input logic        launch,
  input logic        busy
);
  logic bus_active;
  assign bus_active = (bus_cs != 2'b0) || (bus_cmd != 4'b0);

  // R3: a command occupies the bus for one cycle only
  p_bus_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |=> (bus_cs == 2'b0 && bus_cmd == 4'b0 &&
                    bus_ba == 3'b0 && bus_addr == 13'b0));

  // R3, R9: launch drives opcode and rank mask next cycle
  p_launch_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && wr_data[3:0] != 4'd0) |=>
      (bus_cmd == $past(wr_data[3:0]) && bus_cs == $past(wr_data[21:20])));

  // R5: a launch raises the start bit
  p_busy_after_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> rd_data[31]);

  // R6: writes during busy leave the stored fields alone
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] && wr_en) |=> (rd_data[30:0] == $past(rd_data[30:0])));

  // R6: no launch while busy
  p_no_relaunch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);

  // R7: undefined opcodes stay quiet
  p_undef_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31] && !rd_data[31] &&
     (wr_data[3:0] == 4'd7 || wr_data[3:0] > 4'd8)) |=>
      (!rd_data[31] && bus_cmd == 4'b0 && bus_cs == 2'b0));
endmodule

bind dram_cmd_port dram_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .bus_cs(bus_cs), .bus_ba(bus_ba), .bus_addr(bus_addr),
  .bus_cmd(bus_cmd), .launch(launch), .busy(busy)
);

// File: tb/dram_cmd_port_test.sv
module dram_cmd_port_test;
  localparam int TB = 2, TM = 3, TL = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  bus_cs;
  logic [2:0]  bus_ba;
  logic [12:0] bus_addr;
  logic [3:0]  bus_cmd;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_cmd_port #(.T_BASE(TB), .T_MRS(TM), .T_LONG(TL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .bus_cs(bus_cs), .bus_ba(bus_ba),
    .bus_addr(bus_addr), .bus_cmd(bus_cmd)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkword(input bit st, input int rank,
      input int ba, input int addr, input int op);
    return {st, 9'd0, rank[1:0], ba[2:0], addr[12:0], op[3:0]};
  endfunction

  function automatic bit known(input int op);
    return (op >= 0 && op <= 6) || op == 8;
  endfunction

  function automatic int gap(input int op);
    if (op == 2 || op == 5) return TL;
    if (op == 3) return TM;
    return TB;
  endfunction

  function automatic logic [31:0] busword();
    return {8'd0, bus_cs, bus_ba, bus_addr, bus_cmd};
  endfunction

  // Launch one command; optionally poke a write during busy.
  task automatic issue(input int op, input int rank, input int ba,
                       input int addr, input bit poke);
    logic [31:0] w, exp_bus;
    int n;
    w = mkword(1'b1, rank, ba, addr, op);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
    if (known(op) && op != 0)
      exp_bus = {8'd0, rank[1:0], ba[2:0], addr[12:0], op[3:0]};
    else
      exp_bus = '0;
    check(known(op) ? (op == 0 ? "R4 deselect bus" : "R3/R9 bus cycle")
                    : "R7 undefined bus", busword(), exp_bus);
    check("R2 readback fields", {1'b0, rd_data[30:0]}, {1'b0, w[30:0]});
    if (!known(op)) check("R7 no busy", {31'd0, rd_data[31]}, 32'd0);
    n = 0;
    while (rd_data[31] && n < 100) begin
      n++;
      if (n == 2) check("R3 bus idle after one cycle", busword(), 32'd0);
      if (poke && n == 1) begin
        wr_en = 1'b1;
        wr_data = mkword(1'b1, 3 - rank, 7 - ba, 13'h1abc ^ addr, 1);
      end else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R5 busy length", n, known(op) ? gap(op) : 0);
    if (poke) begin
      check("R6 fields kept", {1'b0, rd_data[30:0]}, {1'b0, w[30:0]});
      check("R6 no bus from ignored write", busword(), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rd_data", rd_data, 32'd0);
    check("R1 reset bus", busword(), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 16; op++)
      for (int rk = 0; rk < 4; rk++)
        issue(op, rk, (op + rk) % 8, (op * 611 + rk * 1777) % 8192, rk == 1);

    // R9: both ranks with the top address and bank
    issue(3, 3, 7, 8191, 1'b0);

    // R8: start clear stores fields only
    @(negedge clk); wr_en = 1'b1; wr_data = mkword(1'b0, 2, 5, 1234, 2);
    @(negedge clk); wr_en = 1'b0;
    check("R8 fields stored", rd_data, mkword(1'b0, 2, 5, 1234, 2));
    check("R8 no bus", busword(), 32'd0);
    @(negedge clk);
    check("R8 still idle", {31'd0, rd_data[31]}, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule